// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block stores the general registers and status words of a 32-bit processor core. The core names a register by a 4-bit logical index. Which physical storage word that index reaches depends on the 5-bit processor mode presented alongside it. The physical storage holds 31 general words and 6 status words.

The storage is laid out as follows:
- The fast-interrupt mode has its own copies of indices 8 to 14.
- Four other exception modes keep private stack-pointer (index 13) and link (index 14) words.
- Every other index is shared with user mode.
- Index 15, the program counter, is one word common to all modes.

The block provides these ports:
- Two combinational read ports and one write port that takes effect on the clock edge.
- A port that reads and writes the current status word.
- A port that reads and writes the saved status word belonging to the current mode.
- A user-view control, which lets privileged code reach the user-mode registers.

All pins are plain control or data signals sampled every cycle. There is no handshake, and the block never applies back-pressure: every access completes in the cycle it is presented.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every general register, the current status word and every saved status word read as zero.
- R2: Indices 0 to 7 are one shared set: a write in any mode is read back at the same index in every mode.
- R3: Index 15 (the program counter) is a single word common to every mode.
- R4: In fast-interrupt mode (encoding 0x11), indices 8 to 14 reach private copies. Writes to them leave the user copies unchanged.
- R5: In interrupt (0x12), supervisor (0x13), abort (0x17) and undefined (0x1B) modes, indices 13 and 14 reach copies private to that mode. Indices 8 to 12 reach the user copies.
- R6: User (0x10) and system (0x1F) modes see the same register set.
- R7: A mode encoding that is not one of the seven listed selects the user set.
- R8: With user_view_i high, every general-register access reaches the user set whatever the mode. The saved status port then behaves as in user mode.
- R9: Each of the five exception modes has its own saved status word. The saved status port reads and writes the word of the current mode.
- R10: In user or system mode (and under R7 or R8), the saved status port reads zero and a write to it changes no saved word.
- R11: A read of a register that is written in the same cycle returns the old value. The new value is visible from the next cycle.
- R12: The current status word is written on the clock edge when its write enable is high and is read back on its own output.
- R13: The two read ports are independent: each returns the word selected by its own index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Current processor mode encoding |
| user_view_i | input | 1 | Force all accesses to the user set |
| rd_a_idx_i | input | 4 | Logical index, read port A |
| rd_a_data_o | output | 32 | Read data, port A (combinational) |
| rd_b_idx_i | input | 4 | Logical index, read port B |
| rd_b_data_o | output | 32 | Read data, port B (combinational) |
| wr_en_i | input | 1 | General register write enable |
| wr_idx_i | input | 4 | Logical index to write |
| wr_data_i | input | 32 | General register write data |
| spsr_wr_en_i | input | 1 | Saved status write enable |
| spsr_wr_data_i | input | 32 | Saved status write data |
| spsr_rd_data_o | output | 32 | Saved status word of the current mode |
| cpsr_wr_en_i | input | 1 | Current status write enable |
| cpsr_wr_data_i | input | 32 | Current status write data |
| cpsr_rd_data_o | output | 32 | Current status word |

## Verification
On every cycle, the embedded assertions check four things:
- A write lands in its physical word on the next edge, and no word moves without a write.
- Index 15 always maps to the single program-counter word.
- The user-view control always forces the user bank.
- A saved-status write outside the exception modes leaves every saved word untouched.

Whether a mode reaches the right physical copy can only be shown by the bench's scenarios. They fill the banks with mode-tagged values, read every index in every mode (including system and unknown encodings), and compare both read ports against a behavioural model every cycle. The same applies to the old-value result of a same-cycle read and write.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  localparam int MODE_W = 5;

  localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

  // Bank order matters: the pair-banked modes are consecutive from BK_IRQ.
  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam int N_SAVED      = 5;  // banks that own a saved status word
  localparam int N_PAIR_MODES = 4;  // banks that own only SP/LR copies
endpackage

// File: rtl/rfb_mode_decode.sv
module rfb_mode_decode
  import rfb_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              user_view,
  output bank_e             bank
);
  always_comb begin
    if (user_view) begin
      bank = BK_USR;
    end else begin
      case (mode)
        MODE_FIQ: bank = BK_FIQ;
        MODE_IRQ: bank = BK_IRQ;
        MODE_SVC: bank = BK_SVC;
        MODE_ABT: bank = BK_ABT;
        MODE_UND: bank = BK_UND;
        default:  bank = BK_USR;  // user, system and unknown encodings
      endcase
    end
  end
endmodule

// File: rtl/rfb_index_map.sv
module rfb_index_map
  import rfb_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int PHYS_W  = 5,
  parameter int FIQ_LO  = 8,
  parameter int PAIR_LO = 13
) (
  input  bank_e              bank,
  input  logic [IDX_W-1:0]   idx,
  output logic [PHYS_W-1:0]  phys
);
  localparam int NUM_LOG  = 2 ** IDX_W;
  localparam int PC_IDX   = NUM_LOG - 1;
  localparam int FIQ_CNT  = PC_IDX - FIQ_LO;
  localparam int PAIR_CNT = PC_IDX - PAIR_LO;

  always_comb begin
    phys = PHYS_W'(idx);
    if (int'(idx) != PC_IDX) begin
      if (bank == BK_FIQ && int'(idx) >= FIQ_LO) begin
        phys = PHYS_W'(NUM_LOG + int'(idx) - FIQ_LO);
      end else if (bank != BK_USR && bank != BK_FIQ && int'(idx) >= PAIR_LO) begin
        phys = PHYS_W'(NUM_LOG + FIQ_CNT
                       + (int'(bank) - int'(BK_IRQ)) * PAIR_CNT
                       + int'(idx) - PAIR_LO);
      end
    end
  end
endmodule

// File: rtl/rfb_gpr_store.sv
module rfb_gpr_store #(
  parameter int DATA_W   = 32,
  parameter int NUM_PHYS = 31,
  parameter int PHYS_W   = 5,
  parameter int N_RD     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_RD-1:0][PHYS_W-1:0]  rd_addr,
  output logic [N_RD-1:0][DATA_W-1:0]  rd_data,
  input  logic                         wr_en,
  input  logic [PHYS_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data
);
  logic [NUM_PHYS-1:0][DATA_W-1:0] regs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (wr_en && wr_addr < PHYS_W'(NUM_PHYS)) begin
      regs[wr_addr] <= wr_data;
    end
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    assign rd_data[p] = (rd_addr[p] < PHYS_W'(NUM_PHYS)) ? regs[rd_addr[p]] : '0;
  end

  // R11: the written word holds the new value from the next cycle on
  assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs[$past(wr_addr)] == $past(wr_data));

  // R2: no storage word changes without a write
  assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs));

  // R4: every mapped address lands inside the physical array
  assert_addr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr < PHYS_W'(NUM_PHYS));
endmodule

// File: rtl/rfb_status_store.sv
module rfb_status_store
  import rfb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_e             bank,
  input  logic              spsr_we,
  input  logic [DATA_W-1:0] spsr_wd,
  output logic [DATA_W-1:0] spsr_rd,
  input  logic              cpsr_we,
  input  logic [DATA_W-1:0] cpsr_wd,
  output logic [DATA_W-1:0] cpsr_rd
);
  localparam int SLOT_W = $clog2(N_SAVED);

  logic [N_SAVED-1:0][DATA_W-1:0] saved;
  logic [DATA_W-1:0]              cur;
  logic [SLOT_W-1:0]              slot;
  logic                           has_saved;

  assign has_saved = (bank != BK_USR);
  assign slot      = SLOT_W'(int'(bank) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved <= '0;
      cur   <= '0;
    end else begin
      if (spsr_we && has_saved && slot < SLOT_W'(N_SAVED)) saved[slot] <= spsr_wd;
      if (cpsr_we) cur <= cpsr_wd;
    end
  end

  assign spsr_rd = (has_saved && slot < SLOT_W'(N_SAVED)) ? saved[slot] : '0;
  assign cpsr_rd = cur;

  // R10: a saved-status write in the user bank changes nothing
  assert_user_spsr_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (spsr_we && bank == BK_USR) |=> $stable(saved));

  // R9: a write in an exception bank reaches that bank's own word
  assert_spsr_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (spsr_we && bank != BK_USR) |=> saved[$past(slot)] == $past(spsr_wd));

  // R12: the current status word only moves on its enable
  assert_cpsr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cpsr_we |=> $stable(cur));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rfb_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 4,
  parameter int FIQ_LO  = 8,
  parameter int PAIR_LO = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode_i,
  input  logic              user_view_i,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              spsr_wr_en_i,
  input  logic [DATA_W-1:0] spsr_wr_data_i,
  output logic [DATA_W-1:0] spsr_rd_data_o,
  input  logic              cpsr_wr_en_i,
  input  logic [DATA_W-1:0] cpsr_wr_data_i,
  output logic [DATA_W-1:0] cpsr_rd_data_o
);
  localparam int NUM_LOG  = 2 ** IDX_W;
  localparam int PC_IDX   = NUM_LOG - 1;
  localparam int FIQ_CNT  = PC_IDX - FIQ_LO;
  localparam int PAIR_CNT = PC_IDX - PAIR_LO;
  localparam int NUM_PHYS = NUM_LOG + FIQ_CNT + N_PAIR_MODES * PAIR_CNT;
  localparam int PHYS_W   = $clog2(NUM_PHYS);
  localparam int N_PORTS  = 3;  // two reads, one write

  bank_e bank;
  logic [N_PORTS-1:0][IDX_W-1:0]  port_idx;
  logic [N_PORTS-1:0][PHYS_W-1:0] port_phys;
  logic [1:0][PHYS_W-1:0]         rd_addr;
  logic [1:0][DATA_W-1:0]         rd_data;

  rfb_mode_decode u_decode (
    .mode      (mode_i),
    .user_view (user_view_i),
    .bank      (bank)
  );

  assign port_idx = {wr_idx_i, rd_b_idx_i, rd_a_idx_i};

  for (genvar p = 0; p < N_PORTS; p++) begin : g_map
    rfb_index_map #(
      .IDX_W(IDX_W), .PHYS_W(PHYS_W), .FIQ_LO(FIQ_LO), .PAIR_LO(PAIR_LO)
    ) u_map (
      .bank (bank),
      .idx  (port_idx[p]),
      .phys (port_phys[p])
    );
  end

  assign rd_addr = {port_phys[1], port_phys[0]};

  rfb_gpr_store #(
    .DATA_W(DATA_W), .NUM_PHYS(NUM_PHYS), .PHYS_W(PHYS_W), .N_RD(2)
  ) u_gpr (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (wr_en_i),
    .wr_addr (port_phys[2]),
    .wr_data (wr_data_i)
  );

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];

  rfb_status_store #(.DATA_W(DATA_W)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .bank    (bank),
    .spsr_we (spsr_wr_en_i),
    .spsr_wd (spsr_wr_data_i),
    .spsr_rd (spsr_rd_data_o),
    .cpsr_we (cpsr_wr_en_i),
    .cpsr_wd (cpsr_wr_data_i),
    .cpsr_rd (cpsr_rd_data_o)
  );

  // R8: user view always forces the user bank
  assert_user_view_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    user_view_i |-> bank == BK_USR);

  // R3: the program counter index maps to one word in every mode
  assert_pc_common_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wr_idx_i) == PC_IDX) |-> (int'(port_phys[2]) == PC_IDX));
endmodule

// File: tb/banked_regfile_bench.sv
`timescale 1ns/1ps
module banked_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mode = 5'h10;
  logic        uv = 1'b0;
  logic [3:0]  ra = '0, rb = '0, wi = '0;
  logic        we = 1'b0, swe = 1'b0, cwe = 1'b0;
  logic [31:0] wd = '0, swd = '0, cwd = '0;
  logic [31:0] rda, rdb, srd, crd;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  banked_regfile u_banked_regfile (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .user_view_i(uv),
    .rd_a_idx_i(ra), .rd_a_data_o(rda), .rd_b_idx_i(rb), .rd_b_data_o(rdb),
    .wr_en_i(we), .wr_idx_i(wi), .wr_data_i(wd),
    .spsr_wr_en_i(swe), .spsr_wr_data_i(swd), .spsr_rd_data_o(srd),
    .cpsr_wr_en_i(cwe), .cpsr_wr_data_i(cwd), .cpsr_rd_data_o(crd)
  );

  // Behavioural reference: a full 16-entry view per bank, only owner slots used
  logic [31:0] m_gpr [6][16];
  logic [31:0] m_spsr [6];
  logic [31:0] m_cpsr;

  function automatic int m_bank(logic [4:0] md, logic view);
    if (view) return 0;
    case (md)
      5'h11: return 1;
      5'h12: return 2;
      5'h13: return 3;
      5'h17: return 4;
      5'h1B: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int m_owner(int b, int i);
    if (i == 15) return 0;
    if (b == 1 && i >= 8) return 1;
    if (b >= 2 && i >= 13) return b;
    return 0;
  endfunction

  function automatic logic [31:0] tag(logic [4:0] md, logic [7:0] pass, logic [3:0] i);
    return {3'b000, md, 8'hA5, pass, 4'h0, i};
  endfunction

  task automatic m_clear();
    for (int b = 0; b < 6; b++) begin
      for (int i = 0; i < 16; i++) m_gpr[b][i] = '0;
      m_spsr[b] = '0;
    end
    m_cpsr = '0;
  endtask

  initial m_clear();

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clear();
    end else begin
      int b;
      b = m_bank(mode, uv);
      if (we) m_gpr[m_owner(b, int'(wi))][wi] = wd;
      if (swe && b != 0) m_spsr[b] = swd;
      if (cwe) m_cpsr = cwd;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      int b;
      b = m_bank(mode, uv);
      chk(cur_req, "port A", rda, m_gpr[m_owner(b, int'(ra))][ra]);
      chk(cur_req, "port B", rdb, m_gpr[m_owner(b, int'(rb))][rb]);
      chk(cur_req, "saved status", srd, (b == 0) ? 32'h0 : m_spsr[b]);
      chk(cur_req, "current status", crd, m_cpsr);
    end
  end

  task automatic put(input logic [4:0] md, input logic view,
                     input logic [3:0] a, input logic [3:0] bb,
                     input logic w_en = 1'b0, input logic [3:0] w_i = 4'h0,
                     input logic [31:0] w_d = 32'h0,
                     input logic s_en = 1'b0, input logic [31:0] s_d = 32'h0,
                     input logic c_en = 1'b0, input logic [31:0] c_d = 32'h0);
    @(negedge clk);
    mode = md; uv = view; ra = a; rb = bb;
    we = w_en; wi = w_i; wd = w_d;
    swe = s_en; swd = s_d; cwe = c_en; cwd = c_d;
  endtask

  // Directed probe: present a read, check at +3 ns after the driving edge
  task automatic probe(string req, input logic [4:0] md, input logic view,
                       input logic [3:0] a, input logic [31:0] exp_a,
                       input logic [3:0] bb, input logic [31:0] exp_b);
    put(md, view, a, bb);
    #3;
    chk(req, "probe A", rda, exp_a);
    chk(req, "probe B", rdb, exp_b);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [4:0] exc [5];
    exc = '{5'h11, 5'h12, 5'h13, 5'h17, 5'h1B};

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    for (int i = 0; i < 16; i++) put(5'h10, 1'b0, 4'(i), 4'(15 - i));
    put(5'h11, 1'b0, 4'd9, 4'd14);
    #3;
    chk("R1", "status after reset", crd, 32'h0);
    probe("R1", 5'h13, 1'b0, 4'd13, 32'h0, 4'd15, 32'h0);

    cur_req = "R6";
    for (int i = 0; i < 16; i++) put(5'h10, 1'b0, 4'd0, 4'd1, 1'b1, 4'(i), tag(5'h10, 8'h01, 4'(i)));
    probe("R6", 5'h1F, 1'b0, 4'd13, tag(5'h10, 8'h01, 4'd13), 4'd9, tag(5'h10, 8'h01, 4'd9));

    cur_req = "R4";
    foreach (exc[k]) begin
      for (int i = 0; i < 16; i++) put(exc[k], 1'b0, 4'(i), 4'd15, 1'b1, 4'(i), tag(exc[k], 8'h02, 4'(i)));
    end
    probe("R4", 5'h11, 1'b0, 4'd8, tag(5'h11, 8'h02, 4'd8), 4'd14, tag(5'h11, 8'h02, 4'd14));
    probe("R4", 5'h10, 1'b0, 4'd13, tag(5'h10, 8'h01, 4'd13), 4'd14, tag(5'h10, 8'h01, 4'd14));
    probe("R5", 5'h12, 1'b0, 4'd14, tag(5'h12, 8'h02, 4'd14), 4'd10, tag(5'h1B, 8'h02, 4'd10));
    probe("R5", 5'h13, 1'b0, 4'd13, tag(5'h13, 8'h02, 4'd13), 4'd8, tag(5'h1B, 8'h02, 4'd8));
    probe("R5", 5'h17, 1'b0, 4'd14, tag(5'h17, 8'h02, 4'd14), 4'd13, tag(5'h17, 8'h02, 4'd13));
    probe("R3", 5'h11, 1'b0, 4'd15, tag(5'h1B, 8'h02, 4'd15), 4'd15, tag(5'h1B, 8'h02, 4'd15));
    probe("R2", 5'h17, 1'b0, 4'd3, tag(5'h1B, 8'h02, 4'd3), 4'd7, tag(5'h1B, 8'h02, 4'd7));
    probe("R7", 5'h05, 1'b0, 4'd13, tag(5'h10, 8'h01, 4'd13), 4'd8, tag(5'h1B, 8'h02, 4'd8));

    cur_req = "R13";
    foreach (exc[k]) begin
      for (int i = 0; i < 16; i++) put(exc[k], 1'b0, 4'(i), 4'(15 - i));
    end
    for (int i = 0; i < 16; i++) put(5'h00, 1'b0, 4'(i), 4'(i ^ 5));
    for (int i = 0; i < 16; i++) put(5'h1F, 1'b0, 4'(i), 4'(i ^ 3));

    cur_req = "R8";
    put(5'h11, 1'b1, 4'd0, 4'd1, 1'b1, 4'd9, 32'hDEAD_0009);
    probe("R8", 5'h10, 1'b0, 4'd9, 32'hDEAD_0009, 4'd13, tag(5'h10, 8'h01, 4'd13));
    probe("R8", 5'h11, 1'b0, 4'd9, tag(5'h11, 8'h02, 4'd9), 4'd13, tag(5'h11, 8'h02, 4'd13));

    cur_req = "R9";
    foreach (exc[k]) put(exc[k], 1'b0, 4'd0, 4'd1, 1'b0, 4'd0, 32'h0, 1'b1, 32'h5000_0000 | 32'(exc[k]));
    cur_req = "R10";
    put(5'h10, 1'b0, 4'd0, 4'd1, 1'b0, 4'd0, 32'h0, 1'b1, 32'h0BAD_0010);
    put(5'h1F, 1'b0, 4'd0, 4'd1, 1'b0, 4'd0, 32'h0, 1'b1, 32'h0BAD_001F);
    put(5'h12, 1'b1, 4'd0, 4'd1, 1'b0, 4'd0, 32'h0, 1'b1, 32'h0BAD_0012);
    put(5'h10, 1'b0, 4'd0, 4'd1);
    #3; chk("R10", "user saved status", srd, 32'h0);
    put(5'h1F, 1'b0, 4'd0, 4'd1);
    #3; chk("R10", "system saved status", srd, 32'h0);
    put(5'h11, 1'b0, 4'd0, 4'd1);
    #3; chk("R9", "fiq saved status", srd, 32'h5000_0011);
    put(5'h12, 1'b0, 4'd0, 4'd1);
    #3; chk("R9", "irq saved status", srd, 32'h5000_0012);
    put(5'h12, 1'b1, 4'd0, 4'd1);
    #3; chk("R8", "saved status under user view", srd, 32'h0);
    put(5'h1B, 1'b0, 4'd0, 4'd1);
    #3; chk("R9", "und saved status", srd, 32'h5000_001B);

    cur_req = "R12";
    put(5'h13, 1'b0, 4'd0, 4'd1, 1'b0, 4'd0, 32'h0, 1'b0, 32'h0, 1'b1, 32'h6000_00D3);
    put(5'h10, 1'b0, 4'd0, 4'd1);
    #3; chk("R12", "current status", crd, 32'h6000_00D3);

    cur_req = "R11";
    put(5'h10, 1'b0, 4'd3, 4'd3, 1'b1, 4'd3, 32'h3333_3333);
    #3; chk("R11", "same-cycle read", rda, tag(5'h1B, 8'h02, 4'd3));
    put(5'h10, 1'b0, 4'd3, 4'd2);
    #3; chk("R11", "next-cycle read", rda, 32'h3333_3333);
    put(5'h13, 1'b0, 4'd13, 4'd13, 1'b1, 4'd13, 32'h0513_0D0D);
    #3; chk("R11", "banked same-cycle read", rdb, tag(5'h13, 8'h02, 4'd13));

    put(5'h10, 1'b0, 4'd0, 4'd0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    #3;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule